// File: doc/BRIEF.md
# SMBus Block Transfer Data Buffer

This unit sits between a host-side byte register port and a byte-level bus engine. It carries the data of SMBus block transfers, in both directions. Software sees five byte registers: status, control, a byte-count register, a block-data register and an auxiliary control register. The engine side is a simple handshake. The unit holds a request with a byte to send, or a request to receive one, until the engine acknowledges it.

The unit has two modes, chosen by the auxiliary buffer-enable bit.

- **Buffered mode.** A 32-entry byte buffer is filled or drained through the block-data register. An index selects the entry; it advances on each access and returns to zero whenever the control register is read. The engine moves the whole block without stopping, and completion is flagged once at the end.
- **Byte-by-byte mode.** The engine stops after every data byte and raises a byte-done flag. Software services the block-data register and then clears the flag to release the next byte. In this mode a read signals its final byte by rewriting the control register with the last-byte protocol code.

In both modes the count byte goes first on the bus. For a write it comes from the count register. For a read it is received from the slave and checked.

Top module: `smbus_blkbuf`

## Requirements
- R1: After reset, the status, count and auxiliary registers read 0x00, and no engine request is active.
- R2: Bit 1 (0x02) of the auxiliary register (address 4) enables buffered mode and reads back as written.
- R3: Any read of the control register (address 1) returns the buffer index to entry 0.
- R4: Start is control bit 6, with protocol code 0x14 (bits 5:2 = 5) and direction bit 0 clear (write). In buffered mode this sends the count register (address 2) first, then that many buffer entries in the order they were written. Each write to the block-data register (address 3) stores the next entry.
- R5: A buffered read (direction bit 0 set) loads the received count into the count register. Successive block-data reads then return successive entries. Reads at or beyond the received count return 0x00, and the index saturates at entry 31: a 33rd write overwrites entry 31, and a 33rd read repeats it.
- R6: A valid count lies in 1..32. A write start with an invalid count sets error (status bit 2) and done (status bit 1) and makes no engine request. An invalid received count sets error and done and ends the transfer after the count byte.
- R7: In byte mode, status bit 7 (byte-done) is set after each data byte, and no new request is made until software writes 1 to that bit. In buffered mode byte-done is never set, and completion is a single done flag (status bit 1). Status bit 0 shows busy.
- R8: The engine's last flag marks the final received byte. In byte mode it follows the control protocol code: 0x34 (bits 5:2 = 13) means last. In buffered mode it is raised on the final byte of the count.
- R9: Start is honoured only when the unit is idle; a start written during a transfer has no effect.
- R10: Writing the auxiliary enable to 0 while idle empties the buffer, so later buffered reads return 0x00. The count register is left unchanged.
- R11: An engine request, with its data and last flag, holds steady until it is acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Host register write strobe |
| reg_rd | input | 1 | Host register read strobe (reads of control and block-data have side effects) |
| reg_addr | input | 3 | Register select: 0 status, 1 control, 2 count, 3 block data, 4 auxiliary |
| reg_wdata | input | 8 | Host write data |
| reg_rdata | output | 8 | Host read data for the selected register |
| eng_req | output | 1 | Byte transfer request to the bus engine |
| eng_rd | output | 1 | Request is a receive (1) or a send (0) |
| eng_last | output | 1 | Received byte is the final one, so it is not acknowledged on the bus |
| eng_wdata | output | 8 | Byte to send |
| eng_ack | input | 1 | Engine completed the requested byte |
| eng_rdata | input | 8 | Byte received, valid with eng_ack |

## Verification
The hardest conditions to reach are the byte-mode pause and the index saturation edge. For the pause, the bench must hold byte-done set for several cycles, check that no request appears, and try a stray start in that window. It gets there by polling status until bit 7 is set and then stalling before it writes 1 to clear the bit. Saturation needs exactly 33 accesses against a full 32-byte count. The bench sweeps every count from 1 to 32 in both directions, adds a 33-access pass, and takes each expected byte from a formula of count and position.

// File: rtl/smbus_blkbuf.sv
module smbus_blkbuf #(
  parameter int BUF_DEPTH = 32,
  parameter int AW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic          reg_rd,
  input  logic [AW-1:0] reg_addr,
  input  logic [7:0]    reg_wdata,
  output logic [7:0]    reg_rdata,
  output logic          eng_req,
  output logic          eng_rd,
  output logic          eng_last,
  output logic [7:0]    eng_wdata,
  input  logic          eng_ack,
  input  logic [7:0]    eng_rdata
);
  localparam int IW = $clog2(BUF_DEPTH);
  localparam logic [IW-1:0] IDX_MAX = IW'(BUF_DEPTH - 1);
  localparam logic [AW-1:0] A_STS = 0, A_CTL = 1, A_D0 = 2, A_BLK = 3, A_AUX = 4;
  localparam logic [3:0] P_BLK = 4'h5, P_LAST = 4'hD;

  typedef enum logic [1:0] {S_IDLE, S_CNT, S_DATA, S_WAIT} st_t;

  st_t st;
  logic [7:0] mem [BUF_DEPTH];
  logic [7:0] data0, bdat;
  logic [3:0] proto;
  logic rdir, aux_on, bd, err, intr;
  logic [IW-1:0] idx;
  logic [IW:0] vlen, xcnt, xn;
  logic idle;

  function automatic logic cnt_ok(input logic [7:0] c);
    return (c != 8'd0) && (c <= 8'(BUF_DEPTH));
  endfunction

  assign idle = (st == S_IDLE);
  assign xn = xcnt + 1'b1;
  assign eng_req = (st == S_CNT) || (st == S_DATA);
  assign eng_rd = rdir;
  assign eng_last = (st == S_DATA) && rdir &&
                    (aux_on ? (xn == data0[IW:0]) : (proto == P_LAST));
  assign eng_wdata = (st == S_CNT) ? data0 : (aux_on ? mem[xcnt[IW-1:0]] : bdat);

  always_comb begin
    case (reg_addr)
      A_STS:   reg_rdata = {bd, 4'b0, err, intr, !idle};
      A_CTL:   reg_rdata = {2'b0, proto, 1'b0, rdir};
      A_D0:    reg_rdata = data0;
      A_BLK:   reg_rdata = aux_on ? (({1'b0, idx} < vlen) ? mem[idx] : 8'h00) : bdat;
      A_AUX:   reg_rdata = {6'b0, aux_on, 1'b0};
      default: reg_rdata = 8'h00;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;
      data0 <= '0; bdat <= '0; proto <= '0; rdir <= 1'b0;
      aux_on <= 1'b0; bd <= 1'b0; err <= 1'b0; intr <= 1'b0;
      idx <= '0; vlen <= '0; xcnt <= '0;
      for (int i = 0; i < BUF_DEPTH; i++) mem[i] <= '0;
    end else begin
      if (reg_rd && reg_addr == A_CTL) idx <= '0;
      else if (reg_rd && reg_addr == A_BLK && aux_on && idx != IDX_MAX) idx <= idx + 1'b1;

      if (reg_wr) begin
        case (reg_addr)
          A_STS: begin
            if (reg_wdata[7]) bd <= 1'b0;
            if (reg_wdata[2]) err <= 1'b0;
            if (reg_wdata[1]) intr <= 1'b0;
          end
          A_CTL: begin
            proto <= reg_wdata[5:2];
            rdir <= reg_wdata[0];
            if (reg_wdata[6] && idle &&
                (reg_wdata[5:2] == P_BLK || reg_wdata[5:2] == P_LAST)) begin
              xcnt <= '0;
              if (reg_wdata[0]) begin
                vlen <= '0;
                st <= S_CNT;
              end else if (cnt_ok(data0)) begin
                st <= S_CNT;
              end else begin
                err <= 1'b1;
                intr <= 1'b1;
              end
            end
          end
          A_D0: if (idle) data0 <= reg_wdata;
          A_BLK: begin
            if (aux_on) begin
              if (idle) begin
                mem[idx] <= reg_wdata;
                if (idx != IDX_MAX) idx <= idx + 1'b1;
                if ({1'b0, idx} >= vlen) vlen <= {1'b0, idx} + 1'b1;
              end
            end else if (!eng_req) begin
              bdat <= reg_wdata;
            end
          end
          A_AUX: begin
            aux_on <= reg_wdata[1];
            if (!reg_wdata[1] && idle) begin
              idx <= '0;
              vlen <= '0;
              for (int i = 0; i < BUF_DEPTH; i++) mem[i] <= '0;
            end
          end
          default: ;
        endcase
      end

      case (st)
        S_CNT: if (eng_ack) begin
          if (rdir) begin
            data0 <= eng_rdata;
            if (cnt_ok(eng_rdata)) st <= S_DATA;
            else begin
              err <= 1'b1;
              intr <= 1'b1;
              st <= S_IDLE;
            end
          end else begin
            st <= S_DATA;
          end
        end
        S_DATA: if (eng_ack) begin
          xcnt <= xn;
          if (rdir) begin
            if (aux_on) mem[xcnt[IW-1:0]] <= eng_rdata;
            else bdat <= eng_rdata;
          end
          if (aux_on) begin
            if (xn == data0[IW:0]) begin
              st <= S_IDLE;
              intr <= 1'b1;
              if (rdir) vlen <= xn;
            end
          end else begin
            bd <= 1'b1;
            st <= S_WAIT;
          end
        end
        S_WAIT: if (!bd) begin
          if (xcnt == data0[IW:0]) begin
            st <= S_IDLE;
            intr <= 1'b1;
          end else begin
            st <= S_DATA;
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/smbus_blkbuf_chk.sv
module smbus_blkbuf_chk #(
  parameter int AW = 3,
  parameter int IW = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          reg_rd,
  input logic [AW-1:0] reg_addr,
  input logic          eng_req,
  input logic          eng_rd,
  input logic          eng_last,
  input logic [7:0]    eng_wdata,
  input logic          eng_ack,
  input logic          aux_on,
  input logic          bd,
  input logic [IW-1:0] idx
);
  assert_req_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    eng_req && !eng_ack |=> eng_req && $stable(eng_wdata) && $stable(eng_last));

  assert_no_bytedone_buffered_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bd) |-> !$past(aux_on));

  assert_no_req_while_paused_R7: assert property (@(posedge clk) disable iff (!rst_n)
    bd |-> !eng_req);

  assert_ctl_read_clears_idx_R3: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rd && reg_addr == AW'(1) |=> idx == '0);

  assert_last_only_on_receive_R8: assert property (@(posedge clk) disable iff (!rst_n)
    eng_last |-> eng_rd && eng_req);
endmodule

bind smbus_blkbuf smbus_blkbuf_chk #(.AW(AW), .IW(IW)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_rd(reg_rd), .reg_addr(reg_addr),
  .eng_req(eng_req), .eng_rd(eng_rd), .eng_last(eng_last), .eng_wdata(eng_wdata),
  .eng_ack(eng_ack), .aux_on(aux_on), .bd(bd), .idx(idx)
);

// File: tb/sim_smbus_blkbuf.sv
module sim_smbus_blkbuf;
  localparam int CLK_PER = 10;
  localparam int LOGN = 2048;

  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_wr = 1'b0, reg_rd = 1'b0;
  logic [2:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0, reg_rdata;
  logic eng_req, eng_rd, eng_last, eng_ack;
  logic [7:0] eng_wdata, eng_rdata;

  int checks = 0, errors = 0, lg = 0;
  bit done = 0;
  logic [7:0] logw [LOGN];
  logic       logl [LOGN];
  logic [7:0] rsrc [LOGN];

  always #(CLK_PER/2) clk = ~clk;

  smbus_blkbuf u0 (.*);

  initial begin
    int dly;
    dly = 0;
    eng_ack = 1'b0;
    eng_rdata = '0;
    forever begin
      @(negedge clk);
      if (eng_ack) eng_ack = 1'b0;
      else if (eng_req && rst_n) begin
        if (dly == 0) begin
          logw[lg] = eng_wdata;
          logl[lg] = eng_last;
          eng_rdata = rsrc[lg];
          lg = lg + 1;
          eng_ack = 1'b1;
          dly = lg % 3;
        end else dly = dly - 1;
      end
    end
  end

  function automatic logic [7:0] pat(int n, int k);
    return 8'((n * 37 + k * 11 + 5) & 255);
  endfunction

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [7:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(logic [2:0] a, output logic [7:0] v);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = a;
    #1 v = reg_rdata;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic wait_sts(logic [7:0] mask, string tag);
    logic [7:0] v;
    for (int i = 0; i < 500; i++) begin
      rd(3'd0, v);
      if ((v & mask) != 0) return;
    end
    chk({tag, " status wait"}, 0, 1);
  endtask

  task automatic buf_write(int n, int nw);
    logic [7:0] v;
    int base;
    wr(3'd4, 8'h02);
    rd(3'd1, v);
    wr(3'd2, 8'(n));
    for (int k = 0; k < nw; k++) wr(3'd3, pat(n + nw, k));
    base = lg;
    wr(3'd1, 8'h54);
    wait_sts(8'h02, "R4");
    rd(3'd0, v);
    chk("R7 buffered write status intr only", v, 8'h02);
    chk("R4 byte count on bus", lg - base, n + 1);
    chk("R4 count byte first", logw[base], n);
    for (int k = 0; k < n; k++)
      chk("R4/R5 entry order", logw[base + 1 + k],
          (nw > n && k == n - 1) ? pat(n + nw, nw - 1) : pat(n + nw, k));
    wr(3'd0, 8'h06);
  endtask

  task automatic buf_read(int n);
    logic [7:0] v;
    int base;
    wr(3'd4, 8'h02);
    base = lg;
    rsrc[base] = 8'(n);
    for (int k = 0; k < n; k++) rsrc[base + 1 + k] = pat(n, k + 100);
    wr(3'd1, 8'h55);
    wait_sts(8'h02, "R5");
    rd(3'd0, v);
    chk("R7 buffered read status intr only", v, 8'h02);
    rd(3'd1, v);
    rd(3'd2, v);
    chk("R5 received count in count register", v, n);
    for (int k = 0; k < 33; k++) begin
      rd(3'd3, v);
      chk("R5 successive entries", v,
          k < n ? pat(n, k + 100) : (n == 32 ? pat(n, 131) : 0));
    end
    for (int k = 0; k < n; k++)
      chk("R8 buffered last flag", logl[base + 1 + k], k == n - 1);
    wr(3'd0, 8'h06);
  endtask

  task automatic byte_write(int n);
    logic [7:0] v;
    int base, snap;
    wr(3'd4, 8'h00);
    wr(3'd2, 8'(n));
    wr(3'd3, pat(n, 200));
    base = lg;
    wr(3'd1, 8'h54);
    for (int i = 0; i < n; i++) begin
      wait_sts(8'h80, "R7");
      snap = lg;
      chk("R7 one byte per byte-done", snap - base, i + 2);
      repeat (4) @(negedge clk);
      chk("R7 no request while paused", eng_req, 0);
      if (i == 0) begin
        wr(3'd1, 8'h54);
        rd(3'd0, v);
        chk("R9 start while busy ignored, status", v, 8'h81);
        chk("R9 start while busy ignored, bus", lg, snap);
      end
      if (i < n - 1) wr(3'd3, pat(n, 201 + i));
      wr(3'd0, 8'h80);
    end
    wait_sts(8'h02, "R7");
    chk("R4 byte mode count byte", logw[base], n);
    for (int i = 0; i < n; i++) chk("R7 byte mode data", logw[base + 1 + i], pat(n, 200 + i));
    wr(3'd0, 8'h06);
  endtask

  task automatic byte_read(int n);
    logic [7:0] v;
    int base;
    wr(3'd4, 8'h00);
    base = lg;
    rsrc[base] = 8'(n);
    for (int k = 0; k < n; k++) rsrc[base + 1 + k] = pat(n, 50 + k);
    wr(3'd1, n == 1 ? 8'h75 : 8'h55);
    for (int i = 0; i < n; i++) begin
      wait_sts(8'h80, "R7");
      rd(3'd3, v);
      chk("R7 byte mode read data", v, pat(n, 50 + i));
      if (i == n - 2) wr(3'd1, 8'h35);
      wr(3'd0, 8'h80);
    end
    wait_sts(8'h02, "R7");
    rd(3'd2, v);
    chk("R5 byte mode received count", v, n);
    for (int i = 0; i < n; i++) chk("R8 byte mode last flag", logl[base + 1 + i], i == n - 1);
    wr(3'd0, 8'h06);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    int base;
    for (int i = 0; i < LOGN; i++) rsrc[i] = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1 chk("R1 no request after reset", eng_req, 0);
    rd(3'd0, v); chk("R1 status reset", v, 0);
    rd(3'd2, v); chk("R1 count reset", v, 0);
    rd(3'd4, v); chk("R1 aux reset", v, 0);
    wr(3'd4, 8'h02);
    rd(3'd4, v); chk("R2 buffer enable readback", v, 8'h02);

    wr(3'd2, 8'd4);
    for (int k = 0; k < 4; k++) wr(3'd3, 8'(k + 1));
    rd(3'd3, v); chk("R3 index beyond written entries", v, 0);
    rd(3'd1, v);
    rd(3'd3, v); chk("R3 control read resets index", v, 1);
    rd(3'd3, v); chk("R3 index advances after reset", v, 2);

    for (int n = 1; n <= 32; n++) buf_write(n, n);
    buf_write(32, 33);
    for (int n = 1; n <= 32; n++) buf_read(n);

    foreach (v[b]) ;
    base = lg;
    wr(3'd2, 8'd0);
    wr(3'd1, 8'h54);
    repeat (4) @(negedge clk);
    rd(3'd0, v); chk("R6 zero write count error", v, 8'h06);
    wr(3'd0, 8'h06);
    wr(3'd2, 8'd33);
    wr(3'd1, 8'h54);
    repeat (4) @(negedge clk);
    rd(3'd0, v); chk("R6 oversize write count error", v, 8'h06);
    chk("R6 no bus activity on bad count", lg, base);
    wr(3'd0, 8'h06);
    for (int t = 0; t < 2; t++) begin
      base = lg;
      rsrc[base] = t == 0 ? 8'd0 : 8'd40;
      wr(3'd1, 8'h55);
      wait_sts(8'h02, "R6");
      rd(3'd0, v); chk("R6 bad received count error", v, 8'h06);
      chk("R6 transfer stops after count", lg - base, 1);
      wr(3'd0, 8'h06);
    end

    buf_read(5);
    wr(3'd4, 8'h00);
    rd(3'd4, v); chk("R2 buffer enable clears", v, 0);
    wr(3'd4, 8'h02);
    rd(3'd1, v);
    rd(3'd3, v); chk("R10 buffer emptied", v, 0);
    rd(3'd2, v); chk("R10 count register kept", v, 5);

    byte_write(1);
    byte_write(3);
    byte_write(5);
    byte_read(1);
    byte_read(2);
    byte_read(4);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule